// File: doc/BRIEF.md
# Local Down-Counting Timer with Acknowledged Register Writes

This block is a single timer channel on a 32-bit register bus. Its core is a 32-bit counter that counts down. The tick that drives the counter comes from a timer clock enable. That enable passes through an 8-bit prescaler and then through a power-of-two divider. Software sets the count by writing a load value and sets the run state by writing a control word. Neither write takes effect at once. Each one waits in a small synchroniser and is applied a fixed number of cycles after the bus write. When it is applied, the block sets a write-acknowledge flag. Software polls that flag and clears it by writing 1 to it.

A one-shot delay is programmed in four steps:

1. Stop the counter.
2. Load the count and wait for the load acknowledge.
3. Start the counter.
4. Wait for the start acknowledge.

When the counter steps from one to zero, it sets a sticky expiry flag and then stays at zero. The interrupt output is raised while that flag and its enable bit are both set. Software clears the flag by writing 1 to it.

Each acknowledged write passes through a three-state machine. In SYNC_IDLE nothing is pending. A bus write captures the data and moves to SYNC_HOLD, where a delay counter runs. When the delay counter reaches zero, the machine moves to SYNC_COMMIT. That state lasts one cycle and applies the data, then the machine returns to SYNC_IDLE. A new write arriving in SYNC_HOLD or SYNC_COMMIT replaces the pending data and restarts SYNC_HOLD.

Top module: `lt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The registers are config 0x000, load 0x310, count 0x314, control 0x320, expiry 0x330, enable 0x334 and acknowledge 0x340.
- R2: A write to the load register (0x310) is applied on the third clock edge after the edge that captured it. On that edge the count register (0x314) and the load read-back (0x310) take the written value, and acknowledge bit 2 (0x340) is set. Before that edge none of them changes.
- R3: A write to the control register (0x320) is applied on the third clock edge after capture. From that edge the control register reads back the written word, and acknowledge bit 3 is set. Control bit 3 is the run bit: 1 counts and 0 stops.
- R4: Writing 1 to bit 2 or bit 3 of the acknowledge register clears that bit. Writing 0 leaves it unchanged.
- R5: While running, the count drops by one per tick. One tick lasts (P+1)·2^D enabled timer-clock cycles, where P is config bits [7:0] and D is config bits [10:8]. The first decrement falls exactly one tick period after the start is applied.
- R6: Cycles in which `tclk_en` is low do not advance the tick, so the count holds.
- R7: Once a stop is applied, the count holds its value for as long as the counter stays stopped.
- R8: When the count steps from 1 to 0, bit 1 of the expiry register (0x330) is set and the count stays at zero. Writing 1 to that bit clears it.
- R9: `irq` is high exactly when expiry bit 1 and enable bit 1 (0x334) are both set.
- R10: The config register keeps bits [15:0] as written and reads zeros above them. Bits [15:11] are stored only and have no other effect. A config write takes effect on its capture edge.
- R11: Reads from unmapped offsets return zero. Writes to unmapped offsets, and writes to the read-only count register, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_en | input | 1 | Timer clock enable feeding the prescaler |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Expiry interrupt |

## Verification
The assertions run on every cycle and check local invariants:
- a commit is always preceded by a hold phase;
- a tick occurs only when the timer clock is enabled and the counter is running;
- the count changes only on a load or a tick, and then by exactly one;
- the expiry flag rises only with the count at zero;
- an acknowledge bit rises only on its own commit.

The bench scenarios show what no single-cycle property can. They check the exact three-edge application delay and the tick period for two prescaler and divider settings. They also show the count freezing under a stop or a gated timer clock, the interrupt masking and clearing, and that unmapped and read-only writes are ignored.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int unsigned OFS_CFG   = 'h000;
    localparam int unsigned OFS_LOAD  = 'h310;
    localparam int unsigned OFS_COUNT = 'h314;
    localparam int unsigned OFS_CTRL  = 'h320;
    localparam int unsigned OFS_EXP   = 'h330;
    localparam int unsigned OFS_IEN   = 'h334;
    localparam int unsigned OFS_ACK   = 'h340;

    localparam int RUN_BIT      = 3;
    localparam int EXP_BIT      = 1;
    localparam int ACK_LOAD_BIT = 2;
    localparam int ACK_CTRL_BIT = 3;
    localparam int CFG_W        = 16;

    localparam int NUM_SYNC = 2;
    localparam int CH_LOAD  = 0;
    localparam int CH_CTRL  = 1;

    typedef enum logic [1:0] {
        SYNC_IDLE,
        SYNC_HOLD,
        SYNC_COMMIT
    } sync_state_e;

endpackage

// File: rtl/lt_wsync.sv
module lt_wsync
    import lt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DELAY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [DW-1:0] wdata_i,
    output logic          commit_o,
    output logic [DW-1:0] data_o
);
    // DELAY must be at least 2: one SYNC_HOLD span plus the SYNC_COMMIT cycle.
    localparam int CW = (DELAY > 2) ? $clog2(DELAY - 1) : 1;
    localparam logic [CW-1:0] HOLD_INIT = CW'(DELAY - 2);

    sync_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SYNC_IDLE: begin
                if (capture_i) begin
                    state_d = SYNC_HOLD;
                    cnt_d   = HOLD_INIT;
                end
            end
            SYNC_HOLD: begin
                if (capture_i) begin
                    cnt_d = HOLD_INIT;
                end else if (cnt_q == '0) begin
                    state_d = SYNC_COMMIT;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SYNC_COMMIT: begin
                if (capture_i) begin
                    state_d = SYNC_HOLD;
                    cnt_d   = HOLD_INIT;
                end else begin
                    state_d = SYNC_IDLE;
                end
            end
            default: state_d = SYNC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC_IDLE;
            cnt_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (capture_i) begin
                data_q <= wdata_i;
            end
        end
    end

    always_comb begin
        commit_o = (state_q == SYNC_COMMIT);
        data_o   = data_q;
    end

    assert_commit_follows_hold_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == SYNC_COMMIT) |-> ($past(state_q) == SYNC_HOLD)
    ) else $error("commit entered without hold phase");

endmodule

// File: rtl/lt_tickgen.sv
module lt_tickgen #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tclk_en,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o
);
    localparam int DIVC_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0]  pre_q;
    logic [DIVC_W-1:0] div_q;
    logic [DIVC_W-1:0] div_mask;
    logic              pre_wrap;

    always_comb begin
        pre_wrap = tclk_en && (pre_q == prescale_i);
        div_mask = ~({DIVC_W{1'b1}} << div_sel_i);
        tick_o   = run_i && pre_wrap && ((div_q & div_mask) == div_mask);
    end

    // The phase restarts whenever the counter is stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (!run_i) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (tclk_en) begin
            if (pre_wrap) begin
                pre_q <= '0;
                div_q <= div_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assert_tick_gated_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        tick_o |-> (tclk_en && run_i)
    ) else $error("tick without enable or run");

endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        cnt_o    = cnt_q;
        expire_o = tick_i && !load_i && (cnt_q == ONE);
    end

    assert_hold_without_tick_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q)
    ) else $error("count moved without tick or load");

    assert_single_step_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1)
    ) else $error("count did not step by one");

endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 32,
    parameter int PRE_W      = 8,
    parameter int SEL_W      = 3,
    parameter int SYNC_DELAY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tclk_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam logic [AW-1:0] A_CFG   = AW'(OFS_CFG);
    localparam logic [AW-1:0] A_LOAD  = AW'(OFS_LOAD);
    localparam logic [AW-1:0] A_COUNT = AW'(OFS_COUNT);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_EXP   = AW'(OFS_EXP);
    localparam logic [AW-1:0] A_IEN   = AW'(OFS_IEN);
    localparam logic [AW-1:0] A_ACK   = AW'(OFS_ACK);

    logic [CFG_W-1:0]    cfg_q;
    logic [DW-1:0]       load_q;
    logic [DW-1:0]       ctrl_q;
    logic                exp_q;
    logic                ien_q;
    logic [NUM_SYNC-1:0] ack_q;

    logic [NUM_SYNC-1:0] capture;
    logic [NUM_SYNC-1:0] commit;
    logic [DW-1:0]       sync_data [NUM_SYNC];
    logic [NUM_SYNC-1:0] ack_clr;

    logic          hit_cfg, hit_exp, hit_ien, hit_ack;
    logic          tick, expire;
    logic [DW-1:0] count;

    always_comb begin
        hit_cfg           = bus_wr && (bus_addr == A_CFG);
        hit_exp           = bus_wr && (bus_addr == A_EXP);
        hit_ien           = bus_wr && (bus_addr == A_IEN);
        hit_ack           = bus_wr && (bus_addr == A_ACK);
        capture[CH_LOAD]  = bus_wr && (bus_addr == A_LOAD);
        capture[CH_CTRL]  = bus_wr && (bus_addr == A_CTRL);
        ack_clr[CH_LOAD]  = hit_ack && bus_wdata[ACK_LOAD_BIT];
        ack_clr[CH_CTRL]  = hit_ack && bus_wdata[ACK_CTRL_BIT];
    end

    for (genvar ch = 0; ch < NUM_SYNC; ch++) begin : g_sync
        lt_wsync #(
            .DW    (DW),
            .DELAY (SYNC_DELAY)
        ) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture_i (capture[ch]),
            .wdata_i   (bus_wdata),
            .commit_o  (commit[ch]),
            .data_o    (sync_data[ch])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ack_q[ch] <= 1'b0;
            end else if (commit[ch]) begin
                ack_q[ch] <= 1'b1;
            end else if (ack_clr[ch]) begin
                ack_q[ch] <= 1'b0;
            end
        end

        assert_ack_on_commit_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            $rose(ack_q[ch]) |-> $past(commit[ch])
        ) else $error("acknowledge rose without commit");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            load_q <= '0;
            ctrl_q <= '0;
            exp_q  <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (hit_cfg) begin
                cfg_q <= bus_wdata[CFG_W-1:0];
            end
            if (commit[CH_LOAD]) begin
                load_q <= sync_data[CH_LOAD];
            end
            if (commit[CH_CTRL]) begin
                ctrl_q <= sync_data[CH_CTRL];
            end
            if (expire) begin
                exp_q <= 1'b1;
            end else if (hit_exp && bus_wdata[EXP_BIT]) begin
                exp_q <= 1'b0;
            end
            if (hit_ien) begin
                ien_q <= bus_wdata[EXP_BIT];
            end
        end
    end

    lt_tickgen #(
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl_q[RUN_BIT]),
        .tclk_en    (tclk_en),
        .prescale_i (cfg_q[PRE_W-1:0]),
        .div_sel_i  (cfg_q[PRE_W +: SEL_W]),
        .tick_o     (tick)
    );

    lt_downcount #(
        .W (DW)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (commit[CH_LOAD]),
        .load_val_i (sync_data[CH_LOAD]),
        .tick_i     (tick),
        .cnt_o      (count),
        .expire_o   (expire)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG:   bus_rdata = DW'(cfg_q);
            A_LOAD:  bus_rdata = load_q;
            A_COUNT: bus_rdata = count;
            A_CTRL:  bus_rdata = ctrl_q;
            A_EXP:   bus_rdata[EXP_BIT] = exp_q;
            A_IEN:   bus_rdata[EXP_BIT] = ien_q;
            A_ACK: begin
                bus_rdata[ACK_LOAD_BIT] = ack_q[CH_LOAD];
                bus_rdata[ACK_CTRL_BIT] = ack_q[CH_CTRL];
            end
            default: bus_rdata = '0;
        endcase
        irq = exp_q && ien_q;
    end

    assert_expire_at_zero_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(exp_q) |-> (count == '0)
    ) else $error("expiry flag rose with nonzero count");

endmodule

// File: tb/tb_lt_timer.sv
module tb_lt_timer;

    localparam time CLK_PERIOD = 20ns;
    localparam logic [11:0] A_CFG = 12'h000, A_LOAD = 12'h310, A_COUNT = 12'h314,
                            A_CTRL = 12'h320, A_EXP = 12'h330, A_IEN = 12'h334,
                            A_ACK = 12'h340;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk_en = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
        string       what;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    lt_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tclk_en   (tclk_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: pops the next expected item and compares it with the port.
    always @(sample_ev) begin : monitor
        item_t       it;
        logic [31:0] act;
        if (sb.size() != 0) begin
            it  = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s: actual 0x%08h expected 0x%08h",
                         it.tag, it.what, act, it.exp);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        it.what   = $sformatf("reg 0x%03h", a);
        sb.push_back(it);
        #2;
        -> sample_ev;
        #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1;
        it.exp    = {31'b0, e};
        it.tag    = tag;
        it.what   = "irq";
        sb.push_back(it);
        #2;
        -> sample_ev;
        #1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        expect_reg(A_CFG, 32'h0, "R1");
        expect_reg(A_LOAD, 32'h0, "R1");
        expect_reg(A_COUNT, 32'h0, "R1");
        expect_reg(A_CTRL, 32'h0, "R1");
        expect_reg(A_EXP, 32'h0, "R1");
        expect_reg(A_IEN, 32'h0, "R1");
        expect_reg(A_ACK, 32'h0, "R1");
        expect_irq(1'b0, "R1");

        // R10 config storage
        wr(A_CFG, 32'hFFFF_ABCD);
        expect_reg(A_CFG, 32'h0000_ABCD, "R10");
        wr(A_CFG, 32'h0);
        expect_reg(A_CFG, 32'h0, "R10");

        // R2 load applied on the third edge after capture
        wr(A_LOAD, 32'd5);
        cyc(2);
        expect_reg(A_COUNT, 32'd0, "R2");
        expect_reg(A_ACK, 32'h0, "R2");
        cyc(1);
        expect_reg(A_COUNT, 32'd5, "R2");
        expect_reg(A_LOAD, 32'd5, "R2");
        expect_reg(A_ACK, 32'h4, "R2");

        // R4 acknowledge clear
        wr(A_ACK, 32'h0);
        expect_reg(A_ACK, 32'h4, "R4");
        wr(A_ACK, 32'h4);
        expect_reg(A_ACK, 32'h0, "R4");

        wr(A_IEN, 32'h2);

        // R3 start, R5 with P=0 D=0
        wr(A_CTRL, 32'h8);
        cyc(2);
        expect_reg(A_CTRL, 32'h0, "R3");
        expect_reg(A_COUNT, 32'd5, "R3");
        cyc(1);
        expect_reg(A_CTRL, 32'h8, "R3");
        expect_reg(A_ACK, 32'h8, "R3");
        expect_reg(A_COUNT, 32'd5, "R5");
        cyc(1);
        expect_reg(A_COUNT, 32'd4, "R5");
        cyc(3);
        expect_reg(A_COUNT, 32'd1, "R5");
        expect_reg(A_EXP, 32'h0, "R8");
        expect_irq(1'b0, "R9");
        cyc(1);
        expect_reg(A_COUNT, 32'd0, "R8");
        expect_reg(A_EXP, 32'h2, "R8");
        expect_irq(1'b1, "R9");
        cyc(3);
        expect_reg(A_COUNT, 32'd0, "R8");

        // R9 masking, R8 clear
        wr(A_ACK, 32'h8);
        wr(A_IEN, 32'h0);
        expect_irq(1'b0, "R9");
        expect_reg(A_EXP, 32'h2, "R9");
        wr(A_IEN, 32'h2);
        expect_irq(1'b1, "R9");
        wr(A_EXP, 32'h2);
        expect_reg(A_EXP, 32'h0, "R8");
        expect_irq(1'b0, "R9");

        // stop, reload with P=1 D=1 (period 4)
        wr(A_CTRL, 32'h0);
        cyc(3);
        expect_reg(A_CTRL, 32'h0, "R3");
        wr(A_ACK, 32'h8);
        wr(A_CFG, 32'h0000_0101);
        wr(A_LOAD, 32'd3);
        cyc(3);
        expect_reg(A_COUNT, 32'd3, "R2");
        wr(A_ACK, 32'h4);

        wr(A_CTRL, 32'h8);
        cyc(3);
        expect_reg(A_COUNT, 32'd3, "R5");
        cyc(3);
        expect_reg(A_COUNT, 32'd3, "R5");
        cyc(1);
        expect_reg(A_COUNT, 32'd2, "R5");

        // R7 stop: tick on the apply edge still lands, then frozen
        wr(A_CTRL, 32'h0);
        cyc(3);
        expect_reg(A_COUNT, 32'd1, "R7");
        expect_reg(A_CTRL, 32'h0, "R7");
        cyc(10);
        expect_reg(A_COUNT, 32'd1, "R7");
        expect_reg(A_EXP, 32'h0, "R7");
        wr(A_ACK, 32'h8);

        // R6 gated timer clock
        wr(A_CTRL, 32'h8);
        cyc(3);
        expect_reg(A_COUNT, 32'd1, "R6");
        tclk_en = 1'b0;
        cyc(20);
        expect_reg(A_COUNT, 32'd1, "R6");
        tclk_en = 1'b1;
        cyc(3);
        expect_reg(A_COUNT, 32'd1, "R6");
        cyc(1);
        expect_reg(A_COUNT, 32'd0, "R6");
        expect_reg(A_EXP, 32'h2, "R8");
        wr(A_ACK, 32'h8);

        // R11 unmapped and read-only accesses
        expect_reg(12'h200, 32'h0, "R11");
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h204, 32'hFFFF_FFFF);
        wr(A_COUNT, 32'd77);
        cyc(4);
        expect_reg(12'h204, 32'h0, "R11");
        expect_reg(A_COUNT, 32'd0, "R11");
        expect_reg(A_CFG, 32'h0000_0101, "R11");
        expect_reg(A_LOAD, 32'd3, "R11");
        expect_reg(A_CTRL, 32'h8, "R11");
        expect_reg(A_IEN, 32'h2, "R11");
        expect_reg(A_ACK, 32'h0, "R11");
        expect_reg(A_EXP, 32'h2, "R11");

        cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule